// File: doc/BRIEF.md
# Omission-Tolerant Tick Synchronizer Node

This block is a synchronous model of one member of a fully connected group of nodes that keep a shared tick count. Each of the other nodes in the group reports the last tick number it announced, with a valid flag. Faulty peers may go silent or lose messages, but they never report a false tick. The node keeps its own clock. It emits every tick it sends as a strobe plus a tick number, and each tick number goes out at most once.

Two rules drive the clock. The catch-up rule is a plain OR over the remote inputs. If any single valid remote reports a tick above the local clock, the node replays each missing tick in ascending order, one per cycle, until it reaches the highest tick reported. The advance rule is a quorum rule. If at least f+1 valid remotes report a tick no lower than the local clock, the node sends the next tick. A parameter selects a crash-only variant. That variant has no advance rule, and its group size bound drops from 2f+2 to f+2.

Top module: `tsync_node`

## Requirements
- R1: While rst_ni is low, send_o, busy_o and clock_o are all 0.
- R2: In the first cycle after reset is released, send_o is high with send_tick_o = 0. In the following cycle, send_o is low unless a rule fires.
- R3: Remote k reports its tick on rem_tick_i[k*TICK_W +: TICK_W] and its valid flag on rem_vld_i[k]. If any valid remote reports a tick m greater than clock_o, the node sends clock_o+1, clock_o+2, ... up to m, one per cycle and in order. clock_o always equals the last tick sent.
- R4: A replay that has begun completes even if the remote that triggered it drops its valid flag. If a larger tick is reported during a replay, the replay extends to that larger tick.
- R5: busy_o is high exactly while catch-up ticks are still owed. It is high in every cycle that a later replay send will follow, and it goes low in the cycle the final replayed tick appears.
- R6: In omission mode (CRASH_ONLY = 0), when no valid remote is above the clock and at least F_MAX+1 valid remotes report a tick equal to the clock, the node sends clock+1 once. The node does not advance again until fresh reports arrive.
- R7: When fewer than F_MAX+1 valid remotes report a tick at or above the clock, and none is above it, the node sends nothing.
- R8: A remote whose valid flag is low has no effect, whatever tick value it carries.
- R9: When both rules qualify in the same cycle, catch-up wins. After the replay, the advance rule judges only reports that are at or above the new clock.
- R10: In crash-only mode (CRASH_ONLY = 1), no number of remotes at the current clock makes the node send.
- R11: clock_o changes only together with a send, and each send after the boot send raises clock_o by exactly one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rem_tick_i | input | (N_NODES-1)*TICK_W | Last tick reported by each remote, remote k in slice k |
| rem_vld_i | input | N_NODES-1 | Valid flag per remote |
| send_o | output | 1 | Strobe: a tick is sent this cycle |
| send_tick_o | output | TICK_W | Number of the tick sent |
| clock_o | output | TICK_W | Local tick clock |
| busy_o | output | 1 | Catch-up replay still owes ticks |

## Verification
The interesting case is a cycle in which both rules qualify. A quorum of remotes sits at the current clock while one remote reports a tick two steps ahead. The bench drives exactly this pattern. It checks that the node replays only the two missing ticks, with busy_o high until the last one. It then checks that the quorum reports, now stale, cause no extra tick. A follow-up quorum at the new clock must then produce exactly one advance. Crash-only behaviour is checked on a second instance that sees a full quorum at its clock and must stay silent.

// File: rtl/tsync_pkg.sv
package tsync_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_BOOT  = 2'd1,
    EV_CATCH = 2'd2,
    EV_ADV   = 2'd3
  } tsync_ev_e;
endpackage

// File: rtl/tsync_remote_max.sv
module tsync_remote_max #(
  parameter int unsigned NR     = 5,
  parameter int unsigned TICK_W = 8
) (
  input  logic [NR*TICK_W-1:0] rem_tick_i,
  input  logic [NR-1:0]        rem_vld_i,
  output logic [TICK_W-1:0]    max_o,
  output logic                 any_o
);
  logic [TICK_W-1:0] masked [NR];

  for (genvar k = 0; k < NR; k++) begin : g_mask
    assign masked[k] = rem_vld_i[k] ? rem_tick_i[k*TICK_W +: TICK_W] : '0;
  end

  always_comb begin
    max_o = '0;
    for (int k = 0; k < NR; k++) begin
      if (masked[k] > max_o) max_o = masked[k];
    end
  end

  // catch-up trigger is a plain OR
  assign any_o = |rem_vld_i;
endmodule

// File: rtl/tsync_quorum.sv
module tsync_quorum #(
  parameter int unsigned NR     = 5,
  parameter int unsigned TICK_W = 8,
  parameter int unsigned THRESH = 3
) (
  input  logic [NR*TICK_W-1:0] rem_tick_i,
  input  logic [NR-1:0]        rem_vld_i,
  input  logic [TICK_W-1:0]    clock_i,
  output logic                 reach_o
);
  localparam int unsigned CNT_W = $clog2(NR + 1);

  logic [NR-1:0]    fresh;
  logic [CNT_W-1:0] cnt;

  // stale reports (below clock) never count
  for (genvar k = 0; k < NR; k++) begin : g_fresh
    assign fresh[k] = rem_vld_i[k] && (rem_tick_i[k*TICK_W +: TICK_W] >= clock_i);
  end

  always_comb begin
    cnt = '0;
    for (int k = 0; k < NR; k++) cnt = cnt + CNT_W'(fresh[k]);
  end

  assign reach_o = (32'(cnt) >= THRESH);
endmodule

// File: rtl/tsync_ctrl.sv
module tsync_ctrl
  import tsync_pkg::*;
#(
  parameter int unsigned TICK_W     = 8,
  parameter bit          CRASH_ONLY = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TICK_W-1:0] rem_max_i,
  input  logic              rem_any_i,
  input  logic              quorum_i,
  output logic              send_o,
  output logic [TICK_W-1:0] send_tick_o,
  output logic [TICK_W-1:0] clock_o,
  output logic              busy_o
);
  logic              boot_q;
  logic              send_q;
  logic [TICK_W-1:0] tick_q, clock_q, target_q;
  logic [TICK_W-1:0] catch_tgt, clock_inc;
  tsync_ev_e         ev;

  assign clock_inc = clock_q + 1'b1;
  assign catch_tgt = (rem_any_i && (rem_max_i > target_q)) ? rem_max_i : target_q;

  always_comb begin
    if (boot_q)                                         ev = EV_BOOT;
    else if (catch_tgt > clock_q)                       ev = EV_CATCH;
    else if (!CRASH_ONLY && quorum_i && (clock_q != '1)) ev = EV_ADV;
    else                                                ev = EV_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q   <= 1'b1;
      send_q   <= 1'b0;
      tick_q   <= '0;
      clock_q  <= '0;
      target_q <= '0;
    end else begin
      send_q <= 1'b0;
      unique case (ev)
        EV_BOOT: begin
          boot_q   <= 1'b0;
          send_q   <= 1'b1;
          tick_q   <= '0;
          target_q <= catch_tgt;
        end
        EV_CATCH: begin
          send_q   <= 1'b1;
          tick_q   <= clock_inc;
          clock_q  <= clock_inc;
          target_q <= catch_tgt;
        end
        EV_ADV: begin
          send_q   <= 1'b1;
          tick_q   <= clock_inc;
          clock_q  <= clock_inc;
          target_q <= clock_inc;
        end
        default: ;
      endcase
    end
  end

  assign send_o      = send_q;
  assign send_tick_o = tick_q;
  assign clock_o     = clock_q;
  assign busy_o      = (target_q > clock_q);

  // R2
  boot_send_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_q |=> (send_q && tick_q == '0));

  // R11
  clk_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_q && !$past(boot_q)) |-> (clock_q == TICK_W'($past(clock_q) + 1'b1)));

  // R11
  clk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !send_q |-> $stable(clock_q));

  // R5
  busy_send_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> send_q);

  // R4
  tgt_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    target_q >= clock_q);
endmodule

// File: rtl/tsync_node.sv
module tsync_node #(
  parameter int unsigned N_NODES    = 6,
  parameter int unsigned F_MAX      = 2,
  parameter int unsigned TICK_W     = 8,
  parameter bit          CRASH_ONLY = 1'b0,
  localparam int unsigned NR        = N_NODES - 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NR*TICK_W-1:0] rem_tick_i,
  input  logic [NR-1:0]        rem_vld_i,
  output logic                 send_o,
  output logic [TICK_W-1:0]    send_tick_o,
  output logic [TICK_W-1:0]    clock_o,
  output logic                 busy_o
);
  localparam int unsigned QUORUM = F_MAX + 1;
  localparam int unsigned MIN_N  = CRASH_ONLY ? (F_MAX + 2) : (2 * F_MAX + 2);

  logic [TICK_W-1:0] rem_max;
  logic              rem_any;
  logic              quorum;

  initial begin
    group_size_chk: assert (N_NODES >= MIN_N)
      else $error("group too small for fault bound");
  end

  tsync_remote_max #(.NR(NR), .TICK_W(TICK_W)) u_max (
    .rem_tick_i (rem_tick_i),
    .rem_vld_i  (rem_vld_i),
    .max_o      (rem_max),
    .any_o      (rem_any)
  );

  if (CRASH_ONLY) begin : g_crash
    assign quorum = 1'b0;
  end else begin : g_omit
    tsync_quorum #(.NR(NR), .TICK_W(TICK_W), .THRESH(QUORUM)) u_quorum (
      .rem_tick_i (rem_tick_i),
      .rem_vld_i  (rem_vld_i),
      .clock_i    (clock_o),
      .reach_o    (quorum)
    );
  end

  tsync_ctrl #(.TICK_W(TICK_W), .CRASH_ONLY(CRASH_ONLY)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rem_max_i   (rem_max),
    .rem_any_i   (rem_any),
    .quorum_i    (quorum),
    .send_o      (send_o),
    .send_tick_o (send_tick_o),
    .clock_o     (clock_o),
    .busy_o      (busy_o)
  );

  // R10
  crash_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CRASH_ONLY && !busy_o && !rem_any) |=> !send_o || $past(u_ctrl.boot_q));
endmodule

// File: tb/tsync_node_tb_top.sv
module tsync_node_tb_top;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5ns clk = ~clk;

  logic [5*TW-1:0] o_tick = '0;
  logic [4:0]      o_vld  = '0;
  logic            o_send, o_busy;
  logic [TW-1:0]   o_stick, o_clk;

  logic [3*TW-1:0] c_tick = '0;
  logic [2:0]      c_vld  = '0;
  logic            c_send, c_busy;
  logic [TW-1:0]   c_stick, c_clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  tsync_node #(.N_NODES(6), .F_MAX(2), .TICK_W(TW), .CRASH_ONLY(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rem_tick_i(o_tick), .rem_vld_i(o_vld),
    .send_o(o_send), .send_tick_o(o_stick), .clock_o(o_clk), .busy_o(o_busy));

  tsync_node #(.N_NODES(4), .F_MAX(2), .TICK_W(TW), .CRASH_ONLY(1'b1)) dut_crash_i (
    .clk_i(clk), .rst_ni(rst_n), .rem_tick_i(c_tick), .rem_vld_i(c_vld),
    .send_o(c_send), .send_tick_o(c_stick), .clock_o(c_clk), .busy_o(c_busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // exp_tick < 0 means no send expected
  task automatic exp_o(input string req, input int exp_tick, input bit exp_busy);
    if (exp_tick < 0) begin
      chk(o_send == 1'b0, {req, " send"}, int'(o_send), 0);
    end else begin
      chk(o_send == 1'b1 && int'(o_stick) == exp_tick, {req, " tick"},
          o_send ? int'(o_stick) : -1, exp_tick);
      chk(int'(o_clk) == exp_tick, {req, " clock"}, int'(o_clk), exp_tick);
    end
    chk(o_busy == exp_busy, {req, " busy"}, int'(o_busy), int'(exp_busy));
  endtask

  task automatic set_o(input int idx, input int val, input bit v);
    o_tick[idx*TW +: TW] = TW'(val);
    o_vld[idx] = v;
  endtask

  task automatic t_reset();
    repeat (3) step();
    // R1
    chk(o_send == 0 && o_busy == 0 && o_clk == 0, "R1 omit", int'(o_clk), 0);
    chk(c_send == 0 && c_busy == 0 && c_clk == 0, "R1 crash", int'(c_clk), 0);
    rst_n = 1'b1;
    step();
    // R2
    exp_o("R2 boot", 0, 1'b0);
    chk(c_send == 1 && c_stick == 0, "R2 crash boot", int'(c_stick), 0);
    step();
    exp_o("R2 once", -1, 1'b0);
    chk(c_send == 0, "R2 crash once", int'(c_send), 0);
  endtask

  task automatic t_catchup();
    // R3 R4 R5
    set_o(0, 3, 1'b1);
    step(); exp_o("R3 replay1", 1, 1'b1);
    set_o(0, 0, 1'b0);
    step(); exp_o("R4 replay2", 2, 1'b1);
    step(); exp_o("R5 replay3", 3, 1'b0);
    step(); exp_o("R3 done", -1, 1'b0);
  endtask

  task automatic t_ignore();
    // R8
    for (int k = 0; k < 5; k++) set_o(k, 200, 1'b0);
    repeat (2) begin step(); exp_o("R8 invalid", -1, 1'b0); end
    chk(o_clk == 3, "R8 clock", int'(o_clk), 3);
    for (int k = 0; k < 5; k++) set_o(k, 0, 1'b0);
  endtask

  task automatic t_below_quorum();
    // R7
    set_o(0, 3, 1'b1);
    set_o(1, 3, 1'b1);
    set_o(2, 1, 1'b1);
    repeat (3) begin step(); exp_o("R7 no quorum", -1, 1'b0); end
    for (int k = 0; k < 5; k++) set_o(k, 0, 1'b0);
  endtask

  task automatic t_advance();
    // R6
    for (int k = 0; k < 3; k++) set_o(k, 3, 1'b1);
    step(); exp_o("R6 advance", 4, 1'b0);
    step(); exp_o("R6 stale", -1, 1'b0);
    step(); exp_o("R6 stale2", -1, 1'b0);
    for (int k = 0; k < 5; k++) set_o(k, 0, 1'b0);
  endtask

  task automatic t_both();
    // R9
    for (int k = 0; k < 3; k++) set_o(k, 4, 1'b1);
    set_o(3, 6, 1'b1);
    step(); exp_o("R9 catch5", 5, 1'b1);
    step(); exp_o("R9 catch6", 6, 1'b0);
    step(); exp_o("R9 no extra", -1, 1'b0);
    for (int k = 0; k < 3; k++) set_o(k, 6, 1'b1);
    step(); exp_o("R9 quorum7", 7, 1'b0);
    step(); exp_o("R9 after7", -1, 1'b0);
    for (int k = 0; k < 5; k++) set_o(k, 0, 1'b0);
  endtask

  task automatic t_extend();
    // R4
    set_o(4, 9, 1'b1);
    step(); exp_o("R4 ext8", 8, 1'b1);
    set_o(4, 11, 1'b1);
    step(); exp_o("R4 ext9", 9, 1'b1);
    step(); exp_o("R4 ext10", 10, 1'b1);
    step(); exp_o("R4 ext11", 11, 1'b0);
    step(); exp_o("R4 ext end", -1, 1'b0);
    set_o(4, 0, 1'b0);
  endtask

  task automatic t_crash();
    // R10
    c_vld = 3'b111;
    c_tick = '0;
    repeat (3) begin
      step();
      chk(c_send == 0, "R10 crash no advance", int'(c_send), 0);
    end
    chk(c_clk == 0, "R10 crash clock", int'(c_clk), 0);
    c_tick[0 +: TW] = TW'(2);
    step();
    chk(c_send == 1 && c_stick == 1 && c_busy == 1, "R3 crash catch1", int'(c_stick), 1);
    step();
    chk(c_send == 1 && c_stick == 2 && c_busy == 0, "R3 crash catch2", int'(c_stick), 2);
    step();
    chk(c_send == 0 && c_clk == 2, "R11 crash hold", int'(c_clk), 2);
    c_vld = '0;
  endtask

  initial begin
    t_reset();
    t_catchup();
    t_ignore();
    t_below_quorum();
    t_advance();
    t_both();
    t_extend();
    t_crash();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule